// File: doc/BRIEF.md
# Variable-Length Bitstream Read Port

This block lets a processor pull bit fields of any length from 1 to 16 bits out of a byte-addressed ROM. It keeps a bit pointer, made of a 24-bit byte address and a 3-bit offset inside that byte. It fetches the three bytes starting at the address over a request/valid handshake with the ROM. It then presents a 16-bit window that begins at the pointed bit, read out as a low byte and a high byte.

Software sets the start address and a field width. The pointer then moves forward by that width in one of two ways. In fixed mode, it moves each time the width register is written. In auto mode, it moves as a side effect of reading the high byte, so a decoder can take one field per high-byte read without issuing a separate advance command.

Top module: `vbr_read_port`

## Requirements
- R1: The control register (wr_sel 0) holds the advance mode in bit 7 (0 fixed, 1 auto) and the field width code in bits 3:0. A code of 0 means a width of 16 bits. Writing it with bit 7 set does not move the pointer.
- R2: In fixed mode, each control write adds the width to the bit offset. The address grows by the carry out of the 3-bit offset, and the offset keeps the low 3 bits of the sum.
- R3: wr_sel 1, 2 and 3 load address bits 7:0, 15:8 and 23:16 respectively. Only a write to bits 23:16 also clears the bit offset to 0.
- R4: A read forms a 24-bit word from the bytes at address, address+1 and address+2, with the lowest address in the least significant byte. The word is shifted right by the offset. rd_hi=0 returns bits 7:0 of the result and rd_hi=1 returns bits 15:8.
- R5: In auto mode, a high-byte read advances the pointer by the width after the returned byte is captured. Low-byte reads, and any read in fixed mode, leave the pointer unchanged.
- R6: rom_req stays high with rom_addr unchanged until rom_valid is seen. A byte is taken on a cycle where both rom_req and rom_valid are high.
- R7: Each rd_en pulse gives exactly one rd_ack cycle, with rd_data valid in that cycle. The ack is held back until all three bytes for the current address have been fetched.
- R8: Address arithmetic, both for the pointer and for the fetch addresses, wraps modulo 2^24.
- R9: After reset, the address and offset are 0, the width is 16 in fixed mode, rd_ack is low, and a fetch from address 0 is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1..3 address bytes low to high |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Read request pulse; only when no read is pending |
| rd_hi | input | 1 | Read select: 0 low window byte, 1 high window byte |
| rd_ack | output | 1 | One-cycle read completion |
| rd_data | output | 8 | Read data, valid with rd_ack |
| rom_req | output | 1 | ROM byte request |
| rom_addr | output | 24 | ROM byte address |
| rom_valid | input | 1 | ROM data valid |
| rom_data | input | 8 | ROM data byte |

## Verification
The assertions check, on every cycle:
- the ROM request is held with a stable address;
- an acknowledge always traces back to a request;
- the fetcher is idle whenever the window is usable;
- the pointer changes only on a write or an advance;
- a high-address write clears the offset;
- a fixed-mode control write adds exactly the decoded width.

Returned bytes can only be checked by the bench scenarios, which compare them with a model of the bitstream. These cover several widths, offset carries across byte edges, auto-mode field walks, wrap past the top address, and ROM latencies that make address writes land while a fetch is still in flight.

// File: rtl/vbr_pkg.sv
package vbr_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_A0   = 2'd1,
    SEL_A1   = 2'd2,
    SEL_A2   = 2'd3
  } vbr_sel_e;
endpackage

// File: rtl/vbr_ptr.sv
module vbr_ptr
  import vbr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 3,
  parameter int WID_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic [OFF_W-1:0]  off,
  output logic              auto_mode,
  output logic              addr_chg
);
  localparam int PW      = ADDR_W + OFF_W;
  localparam int LEN_W   = WID_W + 1;
  localparam int A_BYTES = ADDR_W / DATA_W;

  logic [PW-1:0]    pos_q, pos_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             auto_q, auto_d, chg_q;

  function automatic logic [LEN_W-1:0] dec_len(input logic [WID_W-1:0] code);
    return (code == '0) ? LEN_W'(1 << WID_W) : {1'b0, code};
  endfunction

  // advance from a read is applied first, a register write on top of it
  always_comb begin
    pos_d  = pos_q;
    len_d  = len_q;
    auto_d = auto_q;
    if (adv) pos_d = pos_d + PW'(len_q);
    if (wr_en) begin
      if (wr_sel == SEL_CTRL) begin
        auto_d = wr_data[DATA_W-1];
        len_d  = dec_len(wr_data[WID_W-1:0]);
        if (!wr_data[DATA_W-1]) pos_d = pos_d + PW'(len_d);
      end
      for (int k = 0; k < A_BYTES; k++) begin
        if (wr_sel == SEL_W'(k + 1)) begin
          pos_d[OFF_W + k*DATA_W +: DATA_W] = wr_data;
          if (k == A_BYTES - 1) pos_d[OFF_W-1:0] = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      len_q  <= LEN_W'(1 << WID_W);
      auto_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      len_q  <= len_d;
      auto_q <= auto_d;
      chg_q  <= (pos_d[PW-1:OFF_W] != pos_q[PW-1:OFF_W]);
    end
  end

  assign addr      = pos_q[PW-1:OFF_W];
  assign off       = pos_q[OFF_W-1:0];
  assign auto_mode = auto_q;
  assign addr_chg  = chg_q;
endmodule

// File: rtl/vbr_fetch.sv
module vbr_fetch #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int NBYTES = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        base,
  input  logic                     base_chg,
  output logic                     rom_req,
  output logic [ADDR_W-1:0]        rom_addr,
  input  logic                     rom_valid,
  input  logic [DATA_W-1:0]        rom_data,
  output logic [NBYTES*DATA_W-1:0] win_flat,
  output logic                     win_ok
);
  localparam int IDX_W = $clog2(NBYTES);

  logic              req_q, stale_q, full_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              take;

  assign take = req_q & rom_valid & ~stale_q & ~base_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b1;
      addr_q  <= '0;
      idx_q   <= '0;
      stale_q <= 1'b0;
      full_q  <= 1'b0;
    end else if (base_chg) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      if (req_q && !rom_valid) begin
        stale_q <= 1'b1;                 // let the in-flight byte land first
      end else begin
        stale_q <= 1'b0;
        req_q   <= 1'b1;
        addr_q  <= base;
      end
    end else if (req_q && rom_valid) begin
      if (stale_q) begin
        stale_q <= 1'b0;
        addr_q  <= base;
      end else if (idx_q == IDX_W'(NBYTES - 1)) begin
        req_q  <= 1'b0;
        full_q <= 1'b1;
      end else begin
        idx_q  <= idx_q + 1'b1;
        addr_q <= base + ADDR_W'(idx_q) + ADDR_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (take && idx_q == IDX_W'(g)) byte_q <= rom_data;
    end
    assign win_flat[g*DATA_W +: DATA_W] = byte_q;
  end

  assign rom_req  = req_q;
  assign rom_addr = addr_q;
  assign win_ok   = full_q & ~base_chg;
endmodule

// File: rtl/vbr_read_port.sv
module vbr_read_port
  import vbr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 3,
  parameter int WID_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              rd_hi,
  output logic              rd_ack,
  output logic [7:0]        rd_data,
  output logic              rom_req,
  output logic [23:0]       rom_addr,
  input  logic              rom_valid,
  input  logic [7:0]        rom_data
);
  localparam int NBYTES = (2*DATA_W + (1 << OFF_W) - 1 + DATA_W - 1) / DATA_W;
  localparam int WIN_W  = NBYTES * DATA_W;

  logic [ADDR_W-1:0] ptr_addr;
  logic [OFF_W-1:0]  ptr_off;
  logic              auto_mode, addr_chg, adv, win_ok;
  logic [WIN_W-1:0]  win_flat, shifted;
  logic              pend_q, pend_hi_q, ack_q;
  logic [DATA_W-1:0] data_q;
  logic              want, want_hi, serve;

  vbr_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .WID_W(WID_W)) u_ptr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .adv(adv), .addr(ptr_addr), .off(ptr_off), .auto_mode(auto_mode),
    .addr_chg(addr_chg)
  );

  vbr_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES)) u_fetch (
    .clk(clk), .rst(rst), .base(ptr_addr), .base_chg(addr_chg),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_valid(rom_valid),
    .rom_data(rom_data), .win_flat(win_flat), .win_ok(win_ok)
  );

  assign shifted = win_flat >> ptr_off;
  assign want    = pend_q | rd_en;
  assign want_hi = pend_q ? pend_hi_q : rd_hi;
  assign serve   = want & win_ok;
  assign adv     = serve & want_hi & auto_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      pend_hi_q <= 1'b0;
      ack_q     <= 1'b0;
      data_q    <= '0;
    end else begin
      ack_q  <= serve;
      pend_q <= want & ~serve;
      if (!pend_q) pend_hi_q <= rd_hi;
      if (serve) data_q <= want_hi ? shifted[DATA_W +: DATA_W] : shifted[0 +: DATA_W];
    end
  end

  assign rd_ack  = ack_q;
  assign rd_data = data_q;
endmodule

// File: rtl/vbr_read_port_chk.sv
module vbr_read_port_chk
  import vbr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 3,
  parameter int WID_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              rd_ack,
  input logic              rom_req,
  input logic              rom_valid,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [ADDR_W-1:0] ptr_addr,
  input logic [OFF_W-1:0]  ptr_off,
  input logic              adv,
  input logic              pend,
  input logic              win_ok
);
  localparam int PW = ADDR_W + OFF_W;

  logic [PW-1:0] pos, wr_len;
  assign pos    = {ptr_addr, ptr_off};
  assign wr_len = (wr_data[WID_W-1:0] == '0) ? PW'(1 << WID_W) : PW'(wr_data[WID_W-1:0]);

  AST_ROM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rom_req && !rom_valid) |=> (rom_req && $stable(rom_addr))); // R6
  AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> $past(pend || rd_en)); // R7
  AST_WINDOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    win_ok |-> !rom_req); // R7
  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !adv) |=> ($stable(ptr_addr) && $stable(ptr_off))); // R5
  AST_HI_CLEARS_OFF: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_A2) |=> (ptr_off == '0)); // R3
  AST_FIXED_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_CTRL && !wr_data[DATA_W-1] && !adv)
      |=> (pos == $past(pos) + $past(wr_len))); // R2
endmodule

bind vbr_read_port vbr_read_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .WID_W(WID_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_en(rd_en), .rd_ack(rd_ack), .rom_req(rom_req), .rom_valid(rom_valid),
  .rom_addr(rom_addr), .ptr_addr(ptr_addr), .ptr_off(ptr_off), .adv(adv),
  .pend(pend_q), .win_ok(win_ok)
);

// File: tb/sim_vbr_read_port.sv
`timescale 1ns/1ps
module sim_vbr_read_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_hi = 1'b0;
  logic        rd_ack;
  logic [7:0]  rd_data;
  logic        rom_req;
  logic [23:0] rom_addr;
  logic        rom_valid = 1'b0;
  logic [7:0]  rom_data = '0;

  always #2.5 clk = ~clk;

  vbr_read_port u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_hi(rd_hi), .rd_ack(rd_ack), .rd_data(rd_data),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_valid(rom_valid),
    .rom_data(rom_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;
  int lat_mode = 0, lat_cnt = 0;
  logic [7:0] rom_tab [256];
  logic [7:0] exp_d [$];
  string      exp_tag [$];
  int m_addr = 0, m_off = 0, m_wid = 16;
  bit m_auto = 0;

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  function automatic logic [7:0] rom_at(int a);
    logic [23:0] x;
    x = 24'(a);
    return rom_tab[x[7:0] ^ x[15:8] ^ x[23:16]];
  endfunction

  function automatic logic [7:0] exp_port(int a, int o, bit hi);
    int w;
    w = int'(rom_at(a)) | (int'(rom_at(a + 1)) << 8) | (int'(rom_at(a + 2)) << 16);
    w = w >> o;
    return hi ? w[15:8] : w[7:0];
  endfunction

  function automatic int next_lat();
    if (lat_mode == 0) return 0;
    if (lat_mode == 1) return int'(rnd() % 4);
    return 3;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic m_step(int len);
    int t;
    t = m_off + len;
    m_addr = (m_addr + t / 8) & 32'h00FF_FFFF;
    m_off = t % 8;
  endtask

  task automatic do_write(int sel, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
    case (sel)
      0: begin
        m_auto = data[7];
        m_wid = (data[3:0] == 0) ? 16 : int'(data[3:0]);
        if (!m_auto) m_step(m_wid);
      end
      1: m_addr = (m_addr & 32'hFFFF00) | (data & 255);
      2: m_addr = (m_addr & 32'hFF00FF) | ((data & 255) << 8);
      default: begin m_addr = (m_addr & 32'h00FFFF) | ((data & 255) << 16); m_off = 0; end
    endcase
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic set_addr(int a);
    do_write(1, a & 255);
    do_write(2, (a >> 8) & 255);
    do_write(3, (a >> 16) & 255);
  endtask

  task automatic do_read(bit hi, string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_hi = hi;
    exp_d.push_back(exp_port(m_addr, m_off, hi));
    exp_tag.push_back(tag);
    if (hi && m_auto) m_step(m_wid);
    @(posedge clk); #1 rd_en = 1'b0;
    while (exp_d.size() != 0) @(negedge clk);
  endtask

  // ROM model: inline table, programmable latency
  always @(negedge clk) begin
    if (rst) begin
      rom_valid = 1'b0; lat_cnt = 0;
    end else if (rom_req) begin
      if (lat_cnt == 0) begin
        rom_valid = 1'b1; rom_data = rom_at(int'(rom_addr)); lat_cnt = next_lat();
      end else begin
        rom_valid = 1'b0; lat_cnt--;
      end
    end else begin
      rom_valid = 1'b0;
    end
  end

  // read response compare
  always @(negedge clk) begin
    if (!rst && !done && rd_ack) begin
      if (exp_d.size() == 0) chk(1'b0, "R7 ack without request", 1, 0);
      else chk(rd_data == exp_d[0], exp_tag[0], int'(rd_data), int'(exp_d[0]));
      if (exp_d.size() != 0) begin void'(exp_d.pop_front()); void'(exp_tag.pop_front()); end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_up();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) rom_tab[i] = 8'((i * 97 + 13) ^ (i >> 2));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(rd_ack == 1'b0, "R9 rd_ack after reset", int'(rd_ack), 0);
    chk(rom_req == 1'b1, "R9/R6 fetch requested after reset", int'(rom_req), 1);
    chk(rom_addr == 24'h0, "R9 fetch address after reset", int'(rom_addr), 0);

    lat_mode = 1;
    do_read(0, "R9/R4 low at reset pointer");
    do_read(1, "R9/R5 high at reset pointer, fixed mode no advance");
    do_read(0, "R5 pointer unchanged after fixed-mode high read");
    do_write(0, 8'h00);                       // code 0 -> 16 bits
    do_read(0, "R1/R2 width code 0 advances 16");
    do_read(1, "R1/R2 width code 0 high");

    set_addr(24'h123456);
    for (int k = 0; k < 6; k++) begin
      do_write(0, (k * 3 + 3) & 7);
      do_read(0, "R2/R4 fixed-mode low after step");
      do_read(1, "R2/R4 fixed-mode high after step");
    end
    do_write(0, 3);
    do_write(1, 8'h40);
    do_read(0, "R3 low address byte keeps offset");
    do_write(3, 8'h12);
    do_read(1, "R3 high address byte clears offset");

    lat_mode = 2;
    set_addr(24'h00A0F0);
    do_write(0, 8'h85);
    do_read(0, "R1 auto-mode control write does not move pointer");
    for (int k = 0; k < 10; k++) begin
      do_read(0, "R5 auto low read");
      do_read(1, "R5 auto high read");
    end
    do_write(0, 8'h8B);
    for (int k = 0; k < 8; k++) do_read(1, "R5 auto width 11");

    lat_mode = 0;
    set_addr(24'hFFFFFD);
    do_write(0, 8'h80);
    for (int k = 0; k < 4; k++) do_read(1, "R8 wrap past top address");
    set_addr(24'hFFFFFF);
    do_read(0, "R8 fetch wraps within window");

    for (int k = 0; k < 300; k++) begin
      int unsigned r;
      r = rnd();
      if (r % 16 == 0) lat_mode = int'(rnd() % 3);
      case (r % 7)
        0: do_write(0, int'(rnd() & 32'h8F));
        1: do_write(int'(rnd() % 3) + 1, int'(rnd() & 255));
        2, 3: do_read(0, "R4/R6/R7 random low read");
        default: do_read(1, "R4/R5/R6/R7 random high read");
      endcase
    end
    repeat (5) @(negedge clk);
    chk(exp_d.size() == 0, "R7 every read acknowledged", exp_d.size(), 0);
    finish_up();
  end
endmodule